// File: doc/BRIEF.md
# NAND Command Interface State Machine

This block is the device side of a small NAND-style flash part. Command, address and data bytes arrive on an 8-bit bus. A one-cycle valid strobe marks each byte. A command-latch flag and an address-latch flag qualify the byte: command when only the command flag is set, address when only the address flag is set, and data when neither is set. The block decodes these bytes into pointer selection, page program, block erase, status read and reset. It gathers program data in a page buffer that keeps one "loaded" flag per byte. It then runs the timed operation against an on-chip register array, and it drives a ready/busy line and a status byte.

At the default size a page holds 10 bytes: two 4-byte halves and a 2-byte spare area. Sixteen pages form an erase block, and the array holds two blocks. Programming follows flash rules: each programmed byte becomes the old byte ANDed with the new byte, and only an erase returns bytes to FFh. A read port gives combinational access to any array byte, so the stored contents can be observed.

Top module: `nand_ci_top`

## Requirements
- R1: Command 00h sets the column base to 0, 01h sets it to 4, and 50h sets it to 8. These commands are accepted only in idle. The base stays in effect across operations until another pointer command or a reset.
- R2: A program sequence is 80h, then three address bytes (column, row low, row high), then data bytes. Row low bits [4:0] select the page, and the row high byte has no effect at the default size. Data byte i is stored at buffer column base+column+i. Bytes whose position is 10 or more are dropped.
- R3: When a program runs, each column that received a byte becomes old AND new. Every other column of the page is unchanged.
- R4: If no data byte was stored since 80h, command 10h starts nothing. Ready/busy stays high, and the status and the array are unchanged.
- R5: Each page counts its programs since its last erase. A program on a page that has already been programmed 10 times leaves the array unchanged and sets status bit 0. It still holds busy for the program time.
- R6: The sequence 60h, two address bytes, D0h erases the block given by row bit 4. Row bits [3:0] are ignored. Every byte of the 16 pages in that block becomes FFh, their program counts return to zero, and status bit 0 clears.
- R7: rb_o goes low in the cycle after the 10h or D0h byte is latched. It stays low for exactly PROG_CYC cycles (20) for a program and ERASE_CYC cycles (60) for an erase.
- R8: While busy, every byte except the commands FFh and 70h is ignored. The operation, its timing, the pointer and the buffer are unaffected.
- R9: status_o is {0, ready, 00000, fail}. Command 70h raises stat_mode_o, and 70h is accepted in any state. The next accepted command of any other kind clears stat_mode_o.
- R10: Command FFh, accepted in any state, aborts the current operation with no array change. It returns to idle with rb_o high in the next cycle, resets the pointer to base 0, and clears the fail bit.
- R11: A command out of sequence, such as 10h or D0h in idle, is ignored. So is an address or data byte outside its phase.
- R12: After reset, rb_o is 1, status_o is 40h, stat_mode_o is 0 and every array byte is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_vld_i | input | 1 | One-cycle strobe for the byte on io_i |
| cle_i | input | 1 | Byte is a command |
| ale_i | input | 1 | Byte is an address |
| io_i | input | 8 | Bus byte |
| rb_o | output | 1 | High when ready, low when busy |
| status_o | output | 8 | Status byte |
| stat_mode_o | output | 1 | Status read selected by 70h |
| rd_page_i | input | 5 | Array read page |
| rd_col_i | input | 4 | Array read column |
| rd_data_o | output | 8 | Array byte at the read address |

## Verification
The hardest state to reach is the program-count cap. One page has to be driven through ten full successful program sequences, each bracketed by its busy window, before the eleventh attempt can expose the fail bit. The bench does this with a loop over the same page, keeping a model of the AND-accumulated contents. It then erases the page's block, using nonzero page bits in the erase row, and checks that the next program passes. Bytes sent during a busy window are counted into the measured busy length, so the bench sees that they neither stretch nor cut that window.

// File: rtl/nand_ci_pkg.sv
`timescale 1ns/1ps
package nand_ci_pkg;
  localparam logic [7:0] CMD_PTR_A = 8'h00;
  localparam logic [7:0] CMD_PTR_B = 8'h01;
  localparam logic [7:0] CMD_PTR_S = 8'h50;
  localparam logic [7:0] CMD_PROG  = 8'h80;
  localparam logic [7:0] CMD_PGO   = 8'h10;
  localparam logic [7:0] CMD_ERASE = 8'h60;
  localparam logic [7:0] CMD_EGO   = 8'hD0;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_RST   = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PADDR, ST_PDATA, ST_EADDR, ST_EWAIT, ST_BUSY
  } st_e;

  typedef enum logic [1:0] {
    PTR_LO = 2'd0, PTR_HI = 2'd1, PTR_SP = 2'd2
  } ptr_e;
endpackage

// File: rtl/nand_ci_pbuf.sv
`timescale 1ns/1ps
module nand_ci_pbuf #(
  parameter int PAGE_B = 10,
  parameter int CPW    = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [CPW-1:0]         idx_i,
  input  logic [7:0]             din_i,
  output logic [PAGE_B-1:0][7:0] data_o,
  output logic [PAGE_B-1:0]      ld_o,
  output logic                   any_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '1;
      ld_o   <= '0;
    end else if (clr_i) begin
      ld_o <= '0;
    end else if (wr_i) begin
      for (int g = 0; g < PAGE_B; g++) begin
        if (idx_i == CPW'(g)) begin
          data_o[g] <= din_i;
          ld_o[g]   <= 1'b1;
        end
      end
    end
  end

  assign any_o = |ld_o;

  // a write aimed past the page end must not mark any column
  assert_drop_past_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && idx_i >= CPW'(PAGE_B)) |=> $stable(ld_o));
endmodule

// File: rtl/nand_ci_array.sv
`timescale 1ns/1ps
module nand_ci_array #(
  parameter int NUM_PG = 32,
  parameter int PAGE_B = 10,
  parameter int PB_AW  = 4,
  parameter int MAX_PP = 10,
  localparam int PG_AW = $clog2(NUM_PG),
  localparam int BW    = PG_AW - PB_AW,
  localparam int CW    = $clog2(PAGE_B),
  localparam int CNTW  = $clog2(MAX_PP + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   prog_go_i,
  input  logic                   erase_go_i,
  input  logic [PG_AW-1:0]       page_i,
  input  logic [PAGE_B-1:0][7:0] buf_data_i,
  input  logic [PAGE_B-1:0]      buf_ld_i,
  input  logic [PG_AW-1:0]       rd_page_i,
  input  logic [CW-1:0]          rd_col_i,
  output logic [7:0]             rd_data_o,
  output logic                   pp_full_o
);
  logic [PAGE_B-1:0][7:0] mem_q [NUM_PG];
  logic [CNTW-1:0]        pp_q  [NUM_PG];
  logic [NUM_PG-1:0]      pg_wr, pg_er;
  logic [BW-1:0]          blk;

  assign blk = page_i[PG_AW-1:PB_AW];

  for (genvar p = 0; p < NUM_PG; p++) begin : g_hit
    assign pg_wr[p] = prog_go_i  && (page_i == PG_AW'(p));
    assign pg_er[p] = erase_go_i && (blk == BW'(p >> PB_AW));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PG; p++) begin
        mem_q[p] <= '1;
        pp_q[p]  <= '0;
      end
    end else begin
      for (int p = 0; p < NUM_PG; p++) begin
        if (pg_er[p]) begin
          mem_q[p] <= '1;
          pp_q[p]  <= '0;
        end else if (pg_wr[p]) begin
          for (int b = 0; b < PAGE_B; b++)
            if (buf_ld_i[b]) mem_q[p][b] <= mem_q[p][b] & buf_data_i[b];
          pp_q[p] <= pp_q[p] + CNTW'(1);
        end
      end
    end
  end

  assign pp_full_o = pp_q[page_i] >= CNTW'(MAX_PP);
  assign rd_data_o = ({1'b0, rd_col_i} < (CW+1)'(PAGE_B)) ? mem_q[rd_page_i][rd_col_i] : 8'hFF;

  // sequencer must never commit a program on a capped page
  assert_cap_blocks_prog_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_go_i |-> !pp_full_o);
  // erase returns the addressed page's count to zero
  assert_erase_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go_i |=> !pp_full_o);
endmodule

// File: rtl/nand_ci_seq.sv
`timescale 1ns/1ps
module nand_ci_seq
  import nand_ci_pkg::*;
#(
  parameter int HALF_B    = 4,
  parameter int SPARE_B   = 2,
  parameter int PG_AW     = 5,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60,
  localparam int PAGE_B   = 2 * HALF_B + SPARE_B,
  localparam int CPW      = $clog2(2 * HALF_B + 257),
  localparam int TW       = $clog2(ERASE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic [7:0]       io_i,
  input  logic             pp_full_i,
  input  logic             buf_any_i,
  output logic             buf_clr_o,
  output logic             buf_wr_o,
  output logic [CPW-1:0]   buf_idx_o,
  output logic             prog_go_o,
  output logic             erase_go_o,
  output logic [PG_AW-1:0] page_o,
  output logic             rdy_o,
  output logic             fail_o,
  output logic             smode_o
);
  st_e              st_q;
  ptr_e             ptr_q;
  logic [TW-1:0]    tmr_q;
  logic [1:0]       acnt_q;
  logic [CPW-1:0]   col_q, base;
  logic [7:0]       rlo_q;
  logic [PG_AW-1:0] row_q;
  logic             op_prog_q, capped_q, fail_q, smode_q;
  logic             cmd_v, adr_v, dat_v, fin;

  assign cmd_v = vld_i &  cle_i & ~ale_i;
  assign adr_v = vld_i &  ale_i & ~cle_i;
  assign dat_v = vld_i & ~cle_i & ~ale_i;
  assign fin   = (st_q == ST_BUSY) && (tmr_q == '0);

  always_comb begin
    unique case (ptr_q)
      PTR_HI:  base = CPW'(HALF_B);
      PTR_SP:  base = CPW'(2 * HALF_B);
      default: base = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ptr_q     <= PTR_LO;
      tmr_q     <= '0;
      acnt_q    <= '0;
      col_q     <= '0;
      rlo_q     <= '0;
      row_q     <= '0;
      op_prog_q <= 1'b0;
      capped_q  <= 1'b0;
      fail_q    <= 1'b0;
      smode_q   <= 1'b0;
    end else if (cmd_v && io_i == CMD_RST) begin
      st_q    <= ST_IDLE;
      ptr_q   <= PTR_LO;
      tmr_q   <= '0;
      fail_q  <= 1'b0;
      smode_q <= 1'b0;
    end else begin
      if (cmd_v && io_i == CMD_STAT) smode_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_v) begin
            case (io_i)
              CMD_PTR_A: begin ptr_q <= PTR_LO; smode_q <= 1'b0; end
              CMD_PTR_B: begin ptr_q <= PTR_HI; smode_q <= 1'b0; end
              CMD_PTR_S: begin ptr_q <= PTR_SP; smode_q <= 1'b0; end
              CMD_PROG: begin
                st_q <= ST_PADDR; acnt_q <= '0; smode_q <= 1'b0;
              end
              CMD_ERASE: begin
                st_q <= ST_EADDR; acnt_q <= '0; smode_q <= 1'b0;
              end
              default: ;
            endcase
          end
        end
        ST_PADDR: begin
          if (adr_v) begin
            acnt_q <= acnt_q + 2'd1;
            case (acnt_q)
              2'd0:    col_q <= base + CPW'(io_i);
              2'd1:    rlo_q <= io_i;
              default: begin
                row_q <= PG_AW'({io_i, rlo_q});
                st_q  <= ST_PDATA;
              end
            endcase
          end
        end
        ST_PDATA: begin
          if (dat_v && col_q < CPW'(PAGE_B)) col_q <= col_q + CPW'(1);
          if (cmd_v && io_i == CMD_PGO) begin
            smode_q <= 1'b0;
            if (buf_any_i) begin
              st_q      <= ST_BUSY;
              op_prog_q <= 1'b1;
              capped_q  <= pp_full_i;
              tmr_q     <= TW'(PROG_CYC - 1);
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_EADDR: begin
          if (adr_v) begin
            if (acnt_q == 2'd0) begin
              rlo_q  <= io_i;
              acnt_q <= 2'd1;
            end else begin
              row_q <= PG_AW'({io_i, rlo_q});
              st_q  <= ST_EWAIT;
            end
          end
        end
        ST_EWAIT: begin
          if (cmd_v && io_i == CMD_EGO) begin
            st_q      <= ST_BUSY;
            op_prog_q <= 1'b0;
            tmr_q     <= TW'(ERASE_CYC - 1);
            smode_q   <= 1'b0;
          end
        end
        ST_BUSY: begin
          if (tmr_q == '0) begin
            st_q   <= ST_IDLE;
            fail_q <= op_prog_q & capped_q;
          end else begin
            tmr_q <= tmr_q - TW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign buf_clr_o  = cmd_v && ((st_q == ST_IDLE && io_i == CMD_PROG) || io_i == CMD_RST);
  assign buf_wr_o   = dat_v && (st_q == ST_PDATA);
  assign buf_idx_o  = col_q;
  assign prog_go_o  = fin && op_prog_q && !capped_q && !(cmd_v && io_i == CMD_RST);
  assign erase_go_o = fin && !op_prog_q && !(cmd_v && io_i == CMD_RST);
  assign page_o     = row_q;
  assign rdy_o      = (st_q != ST_BUSY);
  assign fail_o     = fail_q;
  assign smode_o    = smode_q;

  // busy only begins right after a launch command byte
  assert_busy_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(cmd_v && (io_i == CMD_PGO || io_i == CMD_EGO)));
  // a non-reset byte during busy does not end the operation early
  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && tmr_q != '0 && !(cmd_v && io_i == CMD_RST)) |=> (st_q == ST_BUSY));
  assert_reset_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_v && io_i == CMD_RST) |=> (rdy_o && ptr_q == PTR_LO && !fail_q && !smode_o));
endmodule

// File: rtl/nand_ci_top.sv
`timescale 1ns/1ps
module nand_ci_top #(
  parameter int HALF_B     = 4,
  parameter int SPARE_B    = 2,
  parameter int PG_PER_BLK = 16,
  parameter int NUM_BLK    = 2,
  parameter int MAX_PP     = 10,
  parameter int PROG_CYC   = 20,
  parameter int ERASE_CYC  = 60,
  localparam int PAGE_B    = 2 * HALF_B + SPARE_B,
  localparam int NUM_PG    = PG_PER_BLK * NUM_BLK,
  localparam int PG_AW     = $clog2(NUM_PG),
  localparam int PB_AW     = $clog2(PG_PER_BLK),
  localparam int CW        = $clog2(PAGE_B),
  localparam int CPW       = $clog2(2 * HALF_B + 257)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_vld_i,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic [7:0]       io_i,
  output logic             rb_o,
  output logic [7:0]       status_o,
  output logic             stat_mode_o,
  input  logic [PG_AW-1:0] rd_page_i,
  input  logic [CW-1:0]    rd_col_i,
  output logic [7:0]       rd_data_o
);
  logic                   buf_clr, buf_wr, buf_any, pp_full;
  logic                   prog_go, erase_go, rdy, fail;
  logic [CPW-1:0]         buf_idx;
  logic [PG_AW-1:0]       page;
  logic [PAGE_B-1:0][7:0] buf_data;
  logic [PAGE_B-1:0]      buf_ld;

  nand_ci_seq #(
    .HALF_B(HALF_B), .SPARE_B(SPARE_B), .PG_AW(PG_AW),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(bus_vld_i), .cle_i(cle_i),
    .ale_i(ale_i), .io_i(io_i), .pp_full_i(pp_full), .buf_any_i(buf_any),
    .buf_clr_o(buf_clr), .buf_wr_o(buf_wr), .buf_idx_o(buf_idx),
    .prog_go_o(prog_go), .erase_go_o(erase_go), .page_o(page),
    .rdy_o(rdy), .fail_o(fail), .smode_o(stat_mode_o)
  );

  nand_ci_pbuf #(.PAGE_B(PAGE_B), .CPW(CPW)) u_pbuf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(buf_clr), .wr_i(buf_wr),
    .idx_i(buf_idx), .din_i(io_i), .data_o(buf_data), .ld_o(buf_ld),
    .any_o(buf_any)
  );

  nand_ci_array #(
    .NUM_PG(NUM_PG), .PAGE_B(PAGE_B), .PB_AW(PB_AW), .MAX_PP(MAX_PP)
  ) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_go_i(prog_go), .erase_go_i(erase_go),
    .page_i(page), .buf_data_i(buf_data), .buf_ld_i(buf_ld),
    .rd_page_i(rd_page_i), .rd_col_i(rd_col_i), .rd_data_o(rd_data_o),
    .pp_full_o(pp_full)
  );

  assign rb_o     = rdy;
  assign status_o = {1'b0, rdy, 5'b00000, fail};
endmodule

// File: tb/nand_ci_top_tb_top.sv
`timescale 1ns/1ps
module nand_ci_top_tb_top;
  localparam int PB = 10;
  localparam int NPG = 32;
  localparam int PROG = 20;
  localparam int ERASE = 60;
  localparam int MAXPP = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, vld, cle, ale;
  logic [7:0] io;
  logic [4:0] rpg;
  logic [3:0] rcol;
  logic       rb, sm;
  logic [7:0] st, rdat;

  nand_ci_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_vld_i(vld), .cle_i(cle), .ale_i(ale),
    .io_i(io), .rb_o(rb), .status_o(st), .stat_mode_o(sm),
    .rd_page_i(rpg), .rd_col_i(rcol), .rd_data_o(rdat)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] m_mem [NPG][PB];
  int  m_pp [NPG];
  int  m_base = 0;
  bit  m_fail = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic c, input logic a, input logic [7:0] b);
    cle = c; ale = a; io = b; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0; cle = 1'b0; ale = 1'b0; io = 8'h00;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rb && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_page(input int pg, input string req);
    for (int b = 0; b < PB; b++) begin
      rpg = 5'(pg); rcol = 4'(b);
      @(negedge clk);
      check(rdat == m_mem[pg][b], req, rdat, m_mem[pg][b]);
    end
  endtask

  task automatic check_status(input string req);
    logic [7:0] e;
    e = {1'b0, 1'b1, 5'b0, m_fail};
    check(st == e, req, st, e);
  endtask

  task automatic run_prog(input int pg, input int col, input int n,
                          input logic [7:0] seed, input string req);
    logic [7:0] td [PB];
    bit tl [PB];
    bit any, capped;
    int idx, cnt;
    for (int b = 0; b < PB; b++) tl[b] = 1'b0;
    any = 1'b0;
    send(1, 0, 8'h80);
    send(0, 1, 8'(col));
    send(0, 1, 8'(pg));
    send(0, 1, 8'h00);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed ^ 8'(i * 29);
      send(0, 0, d);
      idx = m_base + col + i;
      if (idx < PB) begin tl[idx] = 1'b1; td[idx] = d; any = 1'b1; end
    end
    capped = (m_pp[pg] >= MAXPP);
    send(1, 0, 8'h10);
    if (!any) begin
      for (int k = 0; k < 5; k++) begin
        check(rb == 1'b1, "R4 no start", rb, 1);
        @(negedge clk);
      end
      check_status("R4 status");
    end else begin
      wait_rdy(cnt);
      check(cnt == PROG, "R7 program busy", cnt, PROG);
      if (!capped) begin
        for (int b = 0; b < PB; b++) if (tl[b]) m_mem[pg][b] &= td[b];
        m_pp[pg]++;
      end
      m_fail = capped;
      check_status("R9 status after program");
    end
    check_page(pg, req);
  endtask

  task automatic run_erase(input logic [7:0] rlo, input string req);
    int cnt, blk;
    send(1, 0, 8'h60);
    send(0, 1, rlo);
    send(0, 1, 8'h00);
    send(1, 0, 8'hD0);
    wait_rdy(cnt);
    check(cnt == ERASE, "R7 erase busy", cnt, ERASE);
    blk = int'(rlo[4]);
    for (int p = blk * 16; p < blk * 16 + 16; p++) begin
      for (int b = 0; b < PB; b++) m_mem[p][b] = 8'hFF;
      m_pp[p] = 0;
    end
    m_fail = 1'b0;
    check_status(req);
  endtask

  task automatic t_reset;  // R12
    check(rb == 1'b1, "R12 rb", rb, 1);
    check(st == 8'h40, "R12 status", st, 8'h40);
    check(sm == 1'b0, "R12 stat_mode", sm, 0);
    check_page(0, "R12 array erased");
    check_page(31, "R12 array erased");
  endtask

  task automatic t_status_mode;  // R9
    send(1, 0, 8'h70);
    check(sm == 1'b1, "R9 70h sets mode", sm, 1);
    check(st == 8'h40, "R9 status ready", st, 8'h40);
    send(1, 0, 8'h00); m_base = 0;
    check(sm == 1'b0, "R9 mode cleared", sm, 0);
  endtask

  task automatic t_basic;  // R3 R2
    run_prog(3, 1, 2, 8'hA5, "R3 partial program");
    run_prog(3, 1, 3, 8'h3C, "R3 AND with old data");
  endtask

  task automatic t_pointer;  // R1
    send(1, 0, 8'h01); m_base = 4;
    run_prog(3, 0, 1, 8'h0F, "R1 second half");
    run_prog(3, 1, 1, 8'h5A, "R1 pointer persists");
    send(1, 0, 8'h50); m_base = 8;
    run_prog(3, 0, 1, 8'hE7, "R1 spare area");
  endtask

  task automatic t_past_end;  // R2
    run_prog(3, 1, 3, 8'h81, "R2 bytes past end dropped");
  endtask

  task automatic t_empty;  // R4
    run_prog(3, 0, 0, 8'h00, "R4 array unchanged");
  endtask

  task automatic t_out_of_seq;  // R11
    send(1, 0, 8'h10);
    check(rb == 1'b1, "R11 10h in idle", rb, 1);
    send(1, 0, 8'hD0);
    check(rb == 1'b1, "R11 D0h in idle", rb, 1);
    send(0, 0, 8'h00);
    send(0, 1, 8'h03);
    check(rb == 1'b1, "R11 stray bytes", rb, 1);
    check_page(3, "R11 array unchanged");
    run_prog(3, 0, 1, 8'hF3, "R11 sequence intact");
  endtask

  task automatic t_busy_ignore;  // R8
    int n, k;
    send(1, 0, 8'h80);
    send(0, 1, 8'h00);
    send(0, 1, 8'h03);
    send(0, 1, 8'h00);
    send(0, 0, 8'h7E);
    send(1, 0, 8'h10);
    n = 1;
    check(rb == 1'b0, "R8 busy started", rb, 0);
    send(1, 0, 8'h01); n++;
    send(1, 0, 8'h80); n++;
    send(0, 1, 8'h00); n++;
    send(0, 0, 8'h00); n++;
    send(1, 0, 8'h70); n++;
    check(sm == 1'b1, "R8 70h accepted while busy", sm, 1);
    check(rb == 1'b0, "R8 still busy", rb, 0);
    wait_rdy(k);
    n = n + k - 1;
    check(n == PROG, "R8 busy length kept", n, PROG);
    if (m_base < PB) m_mem[3][m_base] &= 8'h7E;
    m_pp[3]++;
    m_fail = 1'b0;
    check_page(3, "R8 bytes during busy ignored");
    run_prog(3, 0, 1, 8'hFE, "R8 pointer unchanged");
  endtask

  task automatic t_abort;  // R10
    run_prog(20, 0, 2, 8'hC3, "R10 setup");
    send(1, 0, 8'h50); m_base = 8;
    send(1, 0, 8'h60);
    send(0, 1, 8'h14);
    send(0, 1, 8'h00);
    send(1, 0, 8'hD0);
    repeat (5) @(negedge clk);
    check(rb == 1'b0, "R10 erase running", rb, 0);
    send(1, 0, 8'hFF);
    m_base = 0;
    check(rb == 1'b1, "R10 ready after abort", rb, 1);
    check(st == 8'h40, "R10 status", st, 8'h40);
    repeat (ERASE) @(negedge clk);
    check_page(20, "R10 no erase");
    run_prog(20, 0, 1, 8'h3F, "R10 pointer back to base 0");
  endtask

  task automatic t_cap;  // R5
    for (int k = 0; k < MAXPP; k++) run_prog(7, k % 4, 1, 8'(8'hF7 - k), "R5 within cap");
    check(st[0] == 1'b0, "R5 tenth passes", st[0], 0);
    run_prog(7, 2, 1, 8'h00, "R5 capped array unchanged");
    check(st == 8'h41, "R5 fail bit", st, 8'h41);
  endtask

  task automatic t_erase;  // R6
    run_erase(8'h0F, "R6 status after erase");
    check_page(7, "R6 page erased");
    check_page(0, "R6 block start erased");
    check_page(15, "R6 block end erased");
    check_page(20, "R6 other block kept");
    run_prog(7, 0, 1, 8'h12, "R6 program after erase");
    check(st == 8'h40, "R6 count cleared", st, 8'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPG; p++) begin
      m_pp[p] = 0;
      for (int b = 0; b < PB; b++) m_mem[p][b] = 8'hFF;
    end
    rst_n = 1'b0; vld = 1'b0; cle = 1'b0; ale = 1'b0; io = 8'h00;
    rpg = '0; rcol = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status_mode();
    t_basic();
    t_pointer();
    t_past_end();
    t_empty();
    t_out_of_seq();
    t_busy_ignore();
    t_abort();
    t_cap();
    t_erase();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule